// File: doc/BRIEF.md
# Push-Pull Gate Driver with Break-Before-Make Gap

This block is a constant-frequency pulse-width modulator for one push-pull power stage. A counter runs freely from 0 to `PERIOD-1` and serves as the ramp. At count 0 a drive latch is set, and when the count reaches the duty level the latch is cleared. The latch picks which of two switches may conduct. The high-side P-type switch is driven through an active-low output and conducts while the latch is set. The low-side N-type switch is driven through an active-high output and conducts while the latch is clear. Each time the latch changes, the switch that is about to turn on is held off for `DEAD` clock cycles, so the two switches never conduct together.

The duty command has the same width as the period counter. It is captured only at the period boundary, and it is clamped so that the latch always stays clear for at least the gap length. Three conditions force both gates off on the next clock: enable low, fault high, or supply-good low. Once all three are back to normal, switching resumes only at the next period boundary. The module also waits for one full period after reset before it starts switching. `DEAD` must be at least 1.

Top module: `pp_pwm_gate`

## Requirements
- R1: During reset and on the first cycles after reset, `p_gate_n` is 1 and `n_gate` is 0, which means both switches are off.
- R2: The period counter wraps from `PERIOD-1` to 0, so the P-side turn-on edges are exactly `PERIOD` cycles apart when the duty is constant.
- R3: Let c be the count and D the captured duty. Then `p_gate_n` is 0 in the cycle after count c exactly when `DEAD <= c < D`.
- R4: `n_gate` is 1 in the cycle after count c exactly when `c >= D + DEAD`. When D = 0 the latch never sets, and `n_gate` stays 1 for the whole period.
- R5: A duty command above `PERIOD-DEAD` is captured as `PERIOD-DEAD`.
- R6: `p_gate_n` = 0 and `n_gate` = 1 never occur in the same cycle. A gate turns on only if the opposite gate was off in the previous cycle.
- R7: If `enable` is 0, `fault` is 1 or `pwr_good` is 0 at a clock edge, both gates are off after that edge.
- R8: After a blocking condition clears, both gates stay off until the count wraps to 0. Switching then follows R3 and R4 from count 0.
- R9: The `duty` input is sampled only at the edge where the count is `PERIOD-1`. A change at any other time has no effect until the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; 0 forces both gates off |
| fault | input | 1 | Protection trip; 1 forces both gates off |
| pwr_good | input | 1 | Synchronous supply-good; 0 forces both gates off |
| duty | input | CW | Duty command in counts |
| p_gate_n | output | 1 | P-side gate, active low |
| n_gate | output | 1 | N-side gate, active high |

## Verification
Two events can fall on the same clock edge. One is the period wrap that would start a new on-phase and lift the post-fault block. The other is a blocking input asserting or clearing on that same edge. The bench sweeps every duty code over several periods. It then toggles `fault`, `enable` and `pwr_good` at every count position, including the wrap count. It compares each cycle's gates against an arithmetic model in which the block has priority over the wrap. A restart counts as correct only if the gates stay off until a wrap that happens with all inputs clean.

// File: rtl/pp_pwm_gate.sv
module pp_pwm_gate #(
  parameter int PERIOD = 500,
  parameter int DEAD   = 20,
  parameter int CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          fault,
  input  logic          pwr_good,
  input  logic [CW-1:0] duty,
  output logic          p_gate_n,
  output logic          n_gate
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] DMAX = CW'(PERIOD - DEAD);
  localparam logic [CW:0]   DW   = (CW+1)'(DEAD);

  logic [CW-1:0] cnt, dsh, dcl;
  logic          blk, ok, wrap, p_on, n_on, go;

  assign ok   = enable & ~fault & pwr_good;
  assign wrap = (cnt == LAST);
  assign dcl  = (duty > DMAX) ? DMAX : duty;
  assign go   = ok & ~blk;
  assign p_on = ({1'b0, cnt} >= DW) && (cnt < dsh);
  assign n_on = (dsh == '0) || ({1'b0, cnt} >= ({1'b0, dsh} + DW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      dsh      <= '0;
      blk      <= 1'b1;
      p_gate_n <= 1'b1;
      n_gate   <= 1'b0;
    end else begin
      cnt      <= wrap ? '0 : cnt + 1'b1;
      if (wrap) dsh <= dcl;
      if (!ok) blk <= 1'b1;
      else if (wrap) blk <= 1'b0;
      p_gate_n <= ~(go & p_on);
      n_gate   <= go & n_on;
    end
  end
endmodule

// File: rtl/pp_pwm_gate_chk.sv
module pp_pwm_gate_chk #(
  parameter int PERIOD = 500,
  parameter int CW     = $clog2(PERIOD)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          fault,
  input logic          pwr_good,
  input logic          p_gate_n,
  input logic          n_gate,
  input logic [CW-1:0] cnt,
  input logic          blk
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!p_gate_n && n_gate));
  a_r6_p_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(p_gate_n) |-> $past(!n_gate));
  a_r6_n_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(n_gate) |-> $past(p_gate_n));
  a_r7_block_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && !fault && pwr_good) |=> (p_gate_n && !n_gate));
  a_r8_restart_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk) |-> ($past(cnt) == LAST));
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST) |=> (cnt == '0));
endmodule

bind pp_pwm_gate pp_pwm_gate_chk #(.PERIOD(PERIOD), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .fault(fault),
  .pwr_good(pwr_good), .p_gate_n(p_gate_n), .n_gate(n_gate),
  .cnt(cnt), .blk(blk)
);

// File: tb/tb_pp_pwm_gate.sv
module tb_pp_pwm_gate;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 12;
  localparam int DT = 2;
  localparam int CW = 4;
  localparam int DMAX = P - DT;

  logic clk = 0, rst_n = 0, enable = 1, fault = 0, pwr_good = 1;
  logic [CW-1:0] duty = '0;
  logic p_gate_n, n_gate;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit run_chk = 0;

  int mc, md;
  bit mblk, e_pn, e_n;
  int cyc = 0, last_on = -1;
  bit prev_pn = 1;
  bit r2_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_pwm_gate #(.PERIOD(P), .DEAD(DT), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fault(fault),
    .pwr_good(pwr_good), .duty(duty), .p_gate_n(p_gate_n), .n_gate(n_gate));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mc <= 0; md <= 0; mblk <= 1; e_pn <= 1; e_n <= 0;
    end else begin
      automatic bit ok = enable && !fault && pwr_good;
      e_pn <= !(ok && !mblk && mc >= DT && mc < md);
      e_n  <= ok && !mblk && (md == 0 || mc >= md + DT);
      if (!ok) mblk <= 1;
      else if (mc == P-1) mblk <= 0;
      if (mc == P-1) md <= (int'(duty) > DMAX) ? DMAX : int'(duty);
      mc <= (mc == P-1) ? 0 : mc + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_chk) begin
      chk({tag, " p_gate_n"}, p_gate_n, e_pn);
      chk({tag, " n_gate"}, n_gate, e_n);
      chk("R6 no overlap", (!p_gate_n && n_gate), 0);
      if (r2_on && prev_pn && !p_gate_n) begin
        if (last_on >= 0) chk("R2 on-edge spacing", cyc - last_on, P);
        last_on = cyc;
      end
      prev_pn = p_gate_n;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_all();
    cycles(3);
    chk("R1 reset p_gate_n", p_gate_n, 1);
    chk("R1 reset n_gate", n_gate, 0);
    rst_n = 1;
    cycles(1);
    chk("R1 post-reset p_gate_n", p_gate_n, 1);
    chk("R1 post-reset n_gate", n_gate, 0);
    run_chk = 1;
    tag = "R3/R4";
    for (int d = 0; d < 16; d++) begin
      duty = CW'(d);
      tag = (d > DMAX) ? "R5" : (d == 0 ? "R4" : "R3");
      r2_on = 0; last_on = -1;
      cycles(P);
      r2_on = (d >= DT + 1);
      cycles(3*P);
    end
    r2_on = 0;
    duty = 4'd6;
    cycles(P);
    tag = "R7";
    for (int k = 0; k < P; k++) begin
      for (int s = 0; s < 3; s++) begin
        cycles(k + 1);
        if (s == 0) fault = 1;
        else if (s == 1) enable = 0;
        else pwr_good = 0;
        cycles(1 + (k % 3));
        fault = 0; enable = 1; pwr_good = 1;
        tag = "R8";
        cycles(2*P);
        tag = "R7";
      end
    end
    tag = "R9";
    for (int i = 0; i < 40*P; i++) begin
      if ($urandom_range(0, 3) == 0) duty = CW'($urandom_range(0, 15));
      if ($urandom_range(0, 60) == 0) fault = 1;
      else fault = 0;
      cycles(1);
    end
    fault = 0;
    cycles(2*P);
    run_chk = 0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule